// File: doc/BRIEF.md
# Three-level extended-address page walker

This block turns a 32-bit linear address into a 36-bit physical address. It does this by reading a chain of three in-memory translation tables. A caller presents a linear address together with the base of the top-level table. The walker then reads 64-bit entries through a single request/response memory port, one read at a time. It returns either the physical address or a fault that names the level where the walk stopped. The reachable physical space is 64 GB, even though the linear space is only 4 GB.

The top level is a four-entry pointer table, selected by linear bits 31:30. Linear bits 29:21 select a directory entry and bits 20:12 select a table entry. Bits 11:0 pass through as the page offset. A directory entry with its large-page flag set ends the walk early and maps a 2 MB page. The walker takes one request at a time and holds its result until the caller acknowledges it.

Top module: `pae_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `mem_req_o` and `res_valid_o` are 0.
- R2: The first read of a walk is at {4'b0, `req_tbl_base_i` (linear-base bits 31:5), lin[31:30], 3'b000}, so its low three address bits are zero.
- R3: The second read is at {pointer entry bits 35:12, lin[29:21], 3'b000}.
- R4: The third read is at {directory entry bits 35:12, lin[20:12], 3'b000}.
- R5: A walk through three present entries ends after exactly three reads. It reports no fault, level code 0, and physical address {table entry bits 35:12, lin[11:0]}. Entry bits 63:36 do not reach the result.
- R6: A present directory entry with bit 7 set ends the walk after two reads. It reports no fault and physical address {directory entry bits 35:21, lin[20:0]}.
- R7: An entry with bit 0 (present) clear ends the walk with no further read. It reports fault=1, physical address 0, and level code 1 (pointer), 2 (directory) or 3 (table).
- R8: A request is taken only while `req_ready_o` is 1, which holds only when idle. A request raised during a walk has no effect on that walk's reads or result.
- R9: `res_valid_o` and the result fields stay stable until `res_ack_i`. One cycle after the acknowledge the walker is idle again.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` answers it. There is only one read outstanding at a time.
- R11: Bit 7 of a pointer or table entry has no effect: the walk still makes all three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_lin_i | input | 32 | Linear address |
| req_tbl_base_i | input | 27 | Pointer-table base, address bits 31:5 |
| mem_req_o | output | 1 | Entry read request, held until answered |
| mem_addr_o | output | 36 | Entry byte address |
| mem_rvalid_i | input | 1 | Read data valid, ends the current read |
| mem_rdata_i | input | 64 | Entry read data |
| res_valid_o | output | 1 | Result valid |
| res_phys_o | output | 36 | Physical address, 0 on fault |
| res_fault_o | output | 1 | Walk ended on a non-present entry |
| res_fault_lvl_o | output | 2 | Fault level: 1 pointer, 2 directory, 3 table, 0 none |
| res_ack_i | input | 1 | Result acknowledge |

## Verification
The walker is tried with several kinds of walk:
- A full small-page walk, which separates correct index slicing at each level from swapped or shifted fields.
- Extreme linear and base values with high frame bits set, which expose truncation above bit 31.
- A large-page directory entry, which shows early termination and the 21-bit offset splice.
- Missing entries at each of the three levels, which separate the level codes and catch any read past a fault.
- Stray flag bits at the other levels, and a request raised mid-walk, which confirm those inputs are ignored.

Memory latency is varied so that a read must be held across idle response cycles.

// File: rtl/pae_pkg.sv
package pae_pkg;
  parameter int LIN_W       = 32;
  parameter int PHYS_W      = 36;
  parameter int ENT_W       = 64;
  parameter int OFF_W       = 12;
  parameter int IDX_W       = 9;
  parameter int TOP_W       = 2;
  parameter int ENT_B_W     = 3;
  parameter int PRESENT_BIT = 0;
  parameter int LARGE_BIT   = 7;

  localparam int FRAME_W     = PHYS_W - OFF_W;
  localparam int LOFF_W      = OFF_W + IDX_W;
  localparam int LFRAME_W    = PHYS_W - LOFF_W;
  localparam int BASE_LO     = TOP_W + ENT_B_W;
  localparam int BASE_W      = LIN_W - BASE_LO;
  localparam int DIR_IDX_HI  = OFF_W + 2 * IDX_W - 1;
  localparam int TBL_IDX_HI  = OFF_W + IDX_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_DIR, ST_TBL, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0, LVL_PTR = 2'd1, LVL_DIR = 2'd2, LVL_TBL = 2'd3
  } lvl_e;
endpackage

// File: rtl/pae_entry_dec.sv
module pae_entry_dec
  import pae_pkg::*;
(
  input  logic [ENT_W-1:0]    entry_i,
  output logic                present_o,
  output logic                large_o,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [LFRAME_W-1:0] lframe_o
);
  logic unused_bits;

  assign present_o = entry_i[PRESENT_BIT];
  assign large_o   = entry_i[LARGE_BIT];
  assign frame_o   = entry_i[PHYS_W-1:OFF_W];
  assign lframe_o  = entry_i[PHYS_W-1:LOFF_W];
  // flag and reserved bits that this walker does not interpret
  assign unused_bits = ^{entry_i[ENT_W-1:PHYS_W], entry_i[OFF_W-1:LARGE_BIT+1],
                         entry_i[LARGE_BIT-1:PRESENT_BIT+1]};
endmodule

// File: rtl/pae_addr_gen.sv
module pae_addr_gen
  import pae_pkg::*;
(
  input  walk_st_e            st_i,
  input  logic [LIN_W-1:0]    lin_i,
  input  logic [BASE_W-1:0]   base_i,
  input  logic [FRAME_W-1:0]  frame_i,
  output logic [PHYS_W-1:0]   addr_o
);
  always_comb begin
    case (st_i)
      ST_DIR:  addr_o = {frame_i, lin_i[DIR_IDX_HI -: IDX_W], {ENT_B_W{1'b0}}};
      ST_TBL:  addr_o = {frame_i, lin_i[TBL_IDX_HI -: IDX_W], {ENT_B_W{1'b0}}};
      default: addr_o = {{(PHYS_W-LIN_W){1'b0}}, base_i, lin_i[LIN_W-1 -: TOP_W],
                         {ENT_B_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/pae_walk_fsm.sv
module pae_walk_fsm
  import pae_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [LIN_W-1:0]    req_lin_i,
  input  logic [BASE_W-1:0]   req_base_i,
  input  logic                rvalid_i,
  input  logic                present_i,
  input  logic                large_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic [LFRAME_W-1:0] lframe_i,
  input  logic                ack_i,
  output walk_st_e            st_o,
  output logic [LIN_W-1:0]    lin_o,
  output logic [BASE_W-1:0]   base_o,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [PHYS_W-1:0]   phys_o,
  output logic                fault_o,
  output logic [1:0]          lvl_o
);
  walk_st_e             st_q;
  logic [LIN_W-1:0]     lin_q;
  logic [BASE_W-1:0]    base_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [PHYS_W-1:0]    phys_q;
  logic                 fault_q;
  lvl_e                 lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lin_q   <= '0;
      base_q  <= '0;
      frame_q <= '0;
      phys_q  <= '0;
      fault_q <= 1'b0;
      lvl_q   <= LVL_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          lin_q  <= req_lin_i;
          base_q <= req_base_i;
          st_q   <= ST_PTR;
        end
        ST_PTR, ST_DIR, ST_TBL: if (rvalid_i) begin
          if (!present_i) begin
            phys_q  <= '0;
            fault_q <= 1'b1;
            lvl_q   <= (st_q == ST_PTR) ? LVL_PTR : (st_q == ST_DIR) ? LVL_DIR : LVL_TBL;
            st_q    <= ST_DONE;
          end else if (st_q == ST_DIR && large_i) begin
            phys_q  <= {lframe_i, lin_q[LOFF_W-1:0]};
            fault_q <= 1'b0;
            lvl_q   <= LVL_NONE;
            st_q    <= ST_DONE;
          end else if (st_q == ST_TBL) begin
            phys_q  <= {frame_i, lin_q[OFF_W-1:0]};
            fault_q <= 1'b0;
            lvl_q   <= LVL_NONE;
            st_q    <= ST_DONE;
          end else begin
            frame_q <= frame_i;
            st_q    <= (st_q == ST_PTR) ? ST_DIR : ST_TBL;
          end
        end
        ST_DONE: if (ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o    = st_q;
  assign lin_o   = lin_q;
  assign base_o  = base_q;
  assign frame_o = frame_q;
  assign phys_o  = phys_q;
  assign fault_o = fault_q;
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/pae_walker.sv
module pae_walker
  import pae_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [LIN_W-1:0]      req_lin_i,
  input  logic [BASE_W-1:0]     req_tbl_base_i,
  output logic                  mem_req_o,
  output logic [PHYS_W-1:0]     mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [ENT_W-1:0]      mem_rdata_i,
  output logic                  res_valid_o,
  output logic [PHYS_W-1:0]     res_phys_o,
  output logic                  res_fault_o,
  output logic [1:0]            res_fault_lvl_o,
  input  logic                  res_ack_i
);
  walk_st_e             st;
  logic [LIN_W-1:0]     lin_q;
  logic [BASE_W-1:0]    base_q;
  logic [FRAME_W-1:0]   frame_q;
  logic                 ent_present;
  logic                 ent_large;
  logic [FRAME_W-1:0]   ent_frame;
  logic [LFRAME_W-1:0]  ent_lframe;

  pae_entry_dec u_dec (
    .entry_i   (mem_rdata_i),
    .present_o (ent_present),
    .large_o   (ent_large),
    .frame_o   (ent_frame),
    .lframe_o  (ent_lframe)
  );

  pae_walk_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_lin_i   (req_lin_i),
    .req_base_i  (req_tbl_base_i),
    .rvalid_i    (mem_rvalid_i),
    .present_i   (ent_present),
    .large_i     (ent_large),
    .frame_i     (ent_frame),
    .lframe_i    (ent_lframe),
    .ack_i       (res_ack_i),
    .st_o        (st),
    .lin_o       (lin_q),
    .base_o      (base_q),
    .frame_o     (frame_q),
    .phys_o      (res_phys_o),
    .fault_o     (res_fault_o),
    .lvl_o       (res_fault_lvl_o)
  );

  pae_addr_gen u_addr (
    .st_i    (st),
    .lin_i   (lin_q),
    .base_i  (base_q),
    .frame_i (frame_q),
    .addr_o  (mem_addr_o)
  );

  assign req_ready_o = (st == ST_IDLE);
  assign mem_req_o   = (st == ST_PTR) || (st == ST_DIR) || (st == ST_TBL);
  assign res_valid_o = (st == ST_DONE);
endmodule

// File: rtl/pae_walker_chk.sv
module pae_walker_chk
  import pae_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic                  mem_req_o,
  input logic [PHYS_W-1:0]     mem_addr_o,
  input logic                  mem_rvalid_i,
  input logic                  res_valid_o,
  input logic [PHYS_W-1:0]     res_phys_o,
  input logic                  res_fault_o,
  input logic [1:0]            res_fault_lvl_o,
  input logic                  res_ack_i
);
  assert_read_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_entry_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ENT_B_W-1:0] == '0));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !res_valid_o));

  assert_accept_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> mem_req_o);

  assert_fault_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> (res_phys_o == '0 && res_fault_lvl_o != 2'd0));

  assert_ok_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_fault_o) |-> (res_fault_lvl_o == 2'd0));

  assert_result_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ack_i) |=> (res_valid_o && $stable(res_phys_o) &&
                                     $stable(res_fault_o) && $stable(res_fault_lvl_o)));

  assert_ack_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ack_i) |=> req_ready_o);
endmodule

bind pae_walker pae_walker_chk u_chk (.*);

// File: tb/pae_walker_tb.sv
module pae_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_lin_i = '0;
  logic [26:0] req_tbl_base_i = '0;
  logic        mem_req_o;
  logic [35:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        res_valid_o;
  logic [35:0] res_phys_o;
  logic        res_fault_o;
  logic [1:0]  res_fault_lvl_o;
  logic        res_ack_i = 1'b0;

  always #10 clk_i = ~clk_i;

  pae_walker u_dut (.*);

  int total = 0;
  int bad = 0;
  logic [63:0] mem [logic [35:0]];
  logic [35:0] exp_q[$];
  logic [35:0] exp_phys;
  logic        exp_fault;
  logic [1:0]  exp_lvl;
  int          exp_reads;
  int          n_reads;
  int          lat_g = 1;
  int          wcnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [63:0] rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] ent(input logic [23:0] frame, input bit p, input bit lg);
    return {28'hA5C3E71, frame, 4'h0, lg, 6'h0, p};
  endfunction

  function automatic logic [35:0] ptr_a(input logic [26:0] b, input logic [31:0] l);
    return {4'h0, b, l[31:30], 3'b000};
  endfunction
  function automatic logic [35:0] dir_a(input logic [63:0] e, input logic [31:0] l);
    return {e[35:12], l[29:21], 3'b000};
  endfunction
  function automatic logic [35:0] tbl_a(input logic [63:0] e, input logic [31:0] l);
    return {e[35:12], l[20:12], 3'b000};
  endfunction

  // behavioural reference: expected read sequence and result
  task automatic model(input logic [31:0] l, input logic [26:0] b);
    logic [63:0] e0, e1, e2;
    exp_q.delete();
    exp_fault = 1'b0; exp_lvl = 2'd0; exp_phys = '0;
    exp_q.push_back(ptr_a(b, l));
    e0 = rd(ptr_a(b, l));
    if (!e0[0]) begin exp_fault = 1'b1; exp_lvl = 2'd1; end
    else begin
      exp_q.push_back(dir_a(e0, l));
      e1 = rd(dir_a(e0, l));
      if (!e1[0]) begin exp_fault = 1'b1; exp_lvl = 2'd2; end
      else if (e1[7]) exp_phys = {e1[35:21], l[20:0]};
      else begin
        exp_q.push_back(tbl_a(e1, l));
        e2 = rd(tbl_a(e1, l));
        if (!e2[0]) begin exp_fault = 1'b1; exp_lvl = 2'd3; end
        else exp_phys = {e2[35:12], l[11:0]};
      end
    end
    exp_reads = exp_q.size();
  endtask

  // memory responder with programmable latency; checks every read address (R2 R3 R4 R10)
  always @(negedge clk_i) begin
    if (mem_rvalid_i) begin
      mem_rvalid_i = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt + 1 >= lat_g) begin
        n_reads++;
        if (exp_q.size() == 0)
          chk(1'b0, "R7 extra read", {28'h0, mem_addr_o}, 64'h0);
        else begin
          logic [35:0] ea;
          ea = exp_q.pop_front();
          chk(mem_addr_o == ea, "R2/R3/R4 read address", {28'h0, mem_addr_o}, {28'h0, ea});
        end
        mem_rdata_i = rd(mem_addr_o);
        mem_rvalid_i = 1'b1;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic walk(input logic [31:0] l, input logic [26:0] b, input int lat,
                      input bit intrude, input string tag);
    bit ready_leak = 1'b0;
    int cyc = 0;
    logic [35:0] hp;
    model(l, b);
    n_reads = 0;
    lat_g = lat;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, {tag, " R8 idle ready"}, {63'h0, req_ready_o}, 64'h1);
    req_lin_i = l; req_tbl_base_i = b; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!res_valid_o) begin
      if (req_ready_o) ready_leak = 1'b1;
      cyc++;
      if (intrude && cyc == 2) begin
        req_lin_i = ~l; req_tbl_base_i = ~b; req_valid_i = 1'b1;
      end else req_valid_i = 1'b0;
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    chk(!ready_leak, {tag, " R8 busy not ready"}, {63'h0, ready_leak}, 64'h0);
    chk(res_phys_o == exp_phys, {tag, " R5/R6 phys"}, {28'h0, res_phys_o}, {28'h0, exp_phys});
    chk(res_fault_o == exp_fault, {tag, " R7 fault"}, {63'h0, res_fault_o}, {63'h0, exp_fault});
    chk(res_fault_lvl_o == exp_lvl, {tag, " R7 level"}, {62'h0, res_fault_lvl_o}, {62'h0, exp_lvl});
    chk(n_reads == exp_reads, {tag, " R5/R6/R7 read count"}, 64'(n_reads), 64'(exp_reads));
    hp = res_phys_o;
    repeat (2) @(negedge clk_i);
    chk(res_valid_o && res_phys_o == hp, {tag, " R9 held"}, {28'h0, res_phys_o}, {28'h0, hp});
    res_ack_i = 1'b1;
    @(negedge clk_i);
    res_ack_i = 1'b0;
    chk(req_ready_o && !res_valid_o, {tag, " R9 idle after ack"},
        {62'h0, req_ready_o, res_valid_o}, 64'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] l;
    logic [26:0] b;
    logic [63:0] e0, e1;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !res_valid_o, "R1 reset state",
        {61'h0, req_ready_o, mem_req_o, res_valid_o}, 64'h4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !mem_req_o && !res_valid_o, "R1 after release",
        {61'h0, req_ready_o, mem_req_o, res_valid_o}, 64'h4);

    // R5 small-page walk
    mem.delete(); l = 32'h8123_4567; b = 27'h000_0800;
    e0 = ent(24'h000123, 1, 0); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h000456, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'hF12345, 1, 0);
    walk(l, b, 1, 0, "R5 walk4k");

    // R5 extreme values, slow memory (R10)
    mem.delete(); l = 32'hFFFF_FFFF; b = 27'h7FF_FFFF;
    e0 = ent(24'hFFFFFF, 1, 0); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h800001, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'hFEDCBA, 1, 0);
    walk(l, b, 4, 0, "R5 R10 extreme");

    mem.delete(); l = 32'h0000_0000; b = 27'h000_0001;
    e0 = ent(24'h000010, 1, 0); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h000020, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'h000030, 1, 0);
    walk(l, b, 2, 0, "R5 zero");

    // R6 large page
    mem.delete(); l = 32'hC03F_FABC; b = 27'h012_3456;
    e0 = ent(24'h00ABCD, 1, 0); mem[ptr_a(b, l)] = e0;
    mem[dir_a(e0, l)] = ent(24'hABC123, 1, 1);
    walk(l, b, 2, 0, "R6 large");

    // R7 faults at each level
    mem.delete(); l = 32'h4000_1000; b = 27'h000_2000;
    walk(l, b, 1, 0, "R7 ptr fault");
    mem.delete(); l = 32'h4020_3000; b = 27'h000_2000;
    e0 = ent(24'h000777, 1, 0); mem[ptr_a(b, l)] = e0;
    mem[dir_a(e0, l)] = ent(24'h123456, 0, 1);
    walk(l, b, 3, 0, "R7 dir fault");
    mem.delete(); l = 32'h7FFF_F123; b = 27'h000_3000;
    e0 = ent(24'h000888, 1, 0); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h000999, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'hFFFFFF, 0, 0);
    walk(l, b, 1, 0, "R7 tbl fault");

    // R11 stray large flag at pointer and table levels
    mem.delete(); l = 32'hA5A5_A5A5; b = 27'h444_4444;
    e0 = ent(24'h0AAAAA, 1, 1); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h055555, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'h933333, 1, 1);
    walk(l, b, 1, 0, "R11 flag ignored");

    // R8 request raised mid-walk is ignored
    mem.delete(); l = 32'h2468_ACE0; b = 27'h135_7913;
    e0 = ent(24'h0F0F0F, 1, 0); mem[ptr_a(b, l)] = e0;
    e1 = ent(24'h3C3C3C, 1, 0); mem[dir_a(e0, l)] = e1;
    mem[tbl_a(e1, l)] = ent(24'h5A5A5A, 1, 0);
    walk(l, b, 2, 1, "R8 intrude");

    repeat (2) @(negedge clk_i);
    report();
  end
endmodule